// File: doc/BRIEF.md
# Debug Run-Control Unit

This unit is the part of an external debug module that starts and stops a single processor hart. A debugger reaches it through a register-access port at the debug-module-interface level. A write to the control word updates the unit's state on the next clock edge. A read returns the addressed word in the same cycle. Toward the hart, the unit drives a halt request and a resume request, and it drives a system reset request. It receives the hart's halted, running and in-reset indications.

The control word carries a global enable bit. While the enable bit is low, the unit holds all its other state in reset and ignores every other field that is written. Once the unit is enabled, it does the following:

- It passes halt requests to the hart.
- It issues resume requests, unless the same write also asks for a halt.
- It tracks the resume acknowledge with a small state machine.
- It can halt the hart as the hart comes out of reset.
- It remembers that a reset happened until the debugger acknowledges it.
- It reports whether the system reset it asked for has finished.

Top module: `dm_runctl`

## Requirements
- R1: After reset, the control word (address 0x10) reads 0x00000000 and the status word (address 0x11) reads 0x000000A3 while the hart is neither halted nor running. The status value is made of a version field of 3 in bits 3:0, reset-halt support in bit 5 and authenticated in bit 7.
- R2: While the enable bit (control bit 0) is low, a control write changes only the enable bit. Writing the enable bit to 0 returns all other state to its reset value, and the halt, resume and system reset outputs are then low.
- R3: A control write with bit 31 set raises `halt_req` in the cycle after the write. A control write with bit 31 clear lowers `halt_req`, unless halt-on-reset is holding it. Control bit 31 reads back the stored halt request.
- R4: A control write with bit 30 set and bit 31 clear raises `resume_req` in the cycle after the write. `resume_req` stays high until `hart_running` is seen, and it drops in the cycle after that.
- R5: A control write with both bit 31 and bit 30 set issues no resume and leaves the resume acknowledge unchanged.
- R6: Status bits 17 and 16 (resume acknowledge) are cleared when a resume is issued. They are set in the cycle after `hart_running` is seen while that resume is pending.
- R7: Status bits 11 and 10 both equal `hart_running`. Status bits 9 and 8 both equal `hart_halted`.
- R8: Control bit 3 sets a sticky halt-on-reset flag and control bit 2 clears it. While the flag is set, a `hart_in_reset` assertion raises `halt_req`. `halt_req` stays high after the reset ends, until `hart_halted` is seen.
- R9: Status bits 19 and 18 are set while `hart_in_reset` is high. They stay set until a control write with bit 28 set.
- R10: Control bit 1 drives `sys_reset_req` and reads back. Status bit 24 reads one from the write that sets control bit 1 until both that bit is low and `hart_in_reset` is low.
- R11: The hart-select fields (control bits 26:6) always read zero, whatever value is written to them. Addresses other than 0x10 and 0x11 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | Access is a write |
| req_addr | input | 7 | Register address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `req_addr`, combinational |
| halt_req | output | 1 | Halt request to the hart |
| resume_req | output | 1 | Resume request to the hart |
| sys_reset_req | output | 1 | System reset request |
| hart_halted | input | 1 | Hart is halted |
| hart_running | input | 1 | Hart is running |
| hart_in_reset | input | 1 | Hart is held in reset |

## Verification
The control word is exercised with several bit patterns:

- A halt alone.
- A resume alone.
- A halt and a resume in the same write, which separates a masked resume from an issued one.
- Writes made while the unit is disabled, which separate blocking from normal decoding.
- Hart-select bits written high, which shows whether those fields are truly tied to zero.

Hart reset pulses are applied with the halt-on-reset flag set and then with it cleared, which separates a sticky flag from a one-shot one. The system reset sequence keeps `hart_in_reset` high after the reset request is withdrawn. This shows whether the pending bit waits for the reset to actually finish.

// File: rtl/dm_runctl.sv
`timescale 1ns/1ps
module dm_runctl #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h11,
  parameter logic [3:0] SPEC_VERSION = 4'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              halt_req,
  output logic              resume_req,
  output logic              sys_reset_req,
  input  logic              hart_halted,
  input  logic              hart_running,
  input  logic              hart_in_reset
);
  localparam int B_HALT = 31, B_RESUME = 30, B_ACKRST = 28;
  localparam int B_SETHOR = 3, B_CLRHOR = 2, B_NDM = 1, B_ACT = 0;

  typedef enum logic [1:0] {RS_IDLE, RS_PEND, RS_ACKED} rs_t;
  typedef enum logic [1:0] {HR_IDLE, HR_ARMED, HR_HOLD} hr_t;

  logic dmactive_q, haltreq_q, ndm_q, ndm_pend_q, hor_flag_q, havereset_q;
  rs_t  rs_q;
  hr_t  hr_q;

  logic wr_ctrl, wr_act, deact, issue;
  assign wr_ctrl = req_valid && req_write && (req_addr == CTRL_ADDR);
  assign wr_act  = wr_ctrl && dmactive_q && req_wdata[B_ACT];
  assign deact   = wr_ctrl && !req_wdata[B_ACT];
  assign issue   = wr_act && req_wdata[B_RESUME] && !req_wdata[B_HALT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dmactive_q <= 1'b0;
    else if (wr_ctrl) dmactive_q <= req_wdata[B_ACT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haltreq_q <= 1'b0;
      ndm_q <= 1'b0;
      ndm_pend_q <= 1'b0;
      hor_flag_q <= 1'b0;
      havereset_q <= 1'b0;
    end else if (!dmactive_q || deact) begin
      haltreq_q <= 1'b0;
      ndm_q <= 1'b0;
      ndm_pend_q <= 1'b0;
      hor_flag_q <= 1'b0;
      havereset_q <= 1'b0;
    end else begin
      if (wr_act) begin
        haltreq_q <= req_wdata[B_HALT];
        ndm_q <= req_wdata[B_NDM];
      end
      if (wr_act && req_wdata[B_SETHOR]) hor_flag_q <= 1'b1;
      else if (wr_act && req_wdata[B_CLRHOR]) hor_flag_q <= 1'b0;
      if (hart_in_reset) havereset_q <= 1'b1;
      else if (wr_act && req_wdata[B_ACKRST]) havereset_q <= 1'b0;
      if (wr_act && req_wdata[B_NDM]) ndm_pend_q <= 1'b1;
      else if (!ndm_q && !hart_in_reset) ndm_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= RS_IDLE;
    else if (!dmactive_q || deact) rs_q <= RS_IDLE;
    else if (issue) rs_q <= RS_PEND;
    else if (rs_q == RS_PEND && hart_running) rs_q <= RS_ACKED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hr_q <= HR_IDLE;
    else if (!dmactive_q || deact) hr_q <= HR_IDLE;
    else begin
      unique case (hr_q)
        HR_IDLE:  if (hart_in_reset && hor_flag_q) hr_q <= HR_ARMED;
        HR_ARMED: if (!hart_in_reset) hr_q <= HR_HOLD;
        HR_HOLD:  if (hart_halted) hr_q <= HR_IDLE;
        default:  hr_q <= HR_IDLE;
      endcase
    end
  end

  assign halt_req      = haltreq_q || (hr_q != HR_IDLE);
  assign resume_req    = (rs_q == RS_PEND);
  assign sys_reset_req = ndm_q;

  logic ack;
  logic [DATA_W-1:0] ctrl_word, stat_word;
  assign ack = (rs_q == RS_ACKED);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_HALT] = haltreq_q;
    ctrl_word[B_NDM]  = ndm_q;
    ctrl_word[B_ACT]  = dmactive_q;
  end

  always_comb begin
    stat_word = '0;
    stat_word[24] = ndm_pend_q;
    stat_word[19] = havereset_q;
    stat_word[18] = havereset_q;
    stat_word[17] = ack;
    stat_word[16] = ack;
    stat_word[11] = hart_running;
    stat_word[10] = hart_running;
    stat_word[9]  = hart_halted;
    stat_word[8]  = hart_halted;
    stat_word[7]  = 1'b1;
    stat_word[5]  = 1'b1;
    stat_word[3:0] = SPEC_VERSION;
  end

  assign rd_data = (req_addr == CTRL_ADDR) ? ctrl_word :
                   (req_addr == STAT_ADDR) ? stat_word : '0;
endmodule

// File: rtl/dm_runctl_chk.sv
`timescale 1ns/1ps
module dm_runctl_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              halt_req,
  input logic              resume_req,
  input logic              sys_reset_req,
  input logic              hart_running,
  input logic              dmactive_q,
  input logic              ndm_pend_q
);
  logic wr_c;
  assign wr_c = req_valid && req_write && (req_addr == CTRL_ADDR);

  p_inactive_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dmactive_q |-> (!halt_req && !resume_req && !sys_reset_req));

  p_halt_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && dmactive_q && req_wdata[0] && req_wdata[31]) |=> halt_req);

  p_resume_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_req && !hart_running && !(wr_c && !req_wdata[0])) |=> resume_req);

  p_resume_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && dmactive_q && req_wdata[0] && req_wdata[31] && req_wdata[30] && !resume_req)
      |=> !resume_req);

  p_pairs_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == STAT_ADDR) |->
      (rd_data[11] == rd_data[10] && rd_data[9] == rd_data[8] && rd_data[19] == rd_data[18]
       && rd_data[17] == rd_data[16]));

  p_pending_covers_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> ndm_pend_q);
endmodule

bind dm_runctl dm_runctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
  .halt_req(halt_req), .resume_req(resume_req), .sys_reset_req(sys_reset_req),
  .hart_running(hart_running), .dmactive_q(dmactive_q), .ndm_pend_q(ndm_pend_q)
);

// File: tb/test_dm_runctl.sv
`timescale 1ns/1ps
module test_dm_runctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rd_data;
  logic halt_req, resume_req, sys_reset_req;
  logic hart_halted = 1'b0, hart_running = 1'b0, hart_in_reset = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dm_runctl i_dm_runctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .halt_req(halt_req), .resume_req(resume_req), .sys_reset_req(sys_reset_req),
    .hart_halted(hart_halted), .hart_running(hart_running), .hart_in_reset(hart_in_reset)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 7'h10; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    req_addr = a;
    #1 d = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(7'h10, d); chk("R1 ctrl after reset", d, 32'h0);
    rd(7'h11, d); chk("R1 status after reset", d, 32'h000000A3);
    chk("R1 outputs low", {29'b0, halt_req, resume_req, sys_reset_req}, 32'h0);
  endtask

  task automatic t_inactive;
    logic [31:0] d;
    wr(32'h8000_0009);
    chk("R2 halt blocked while inactive", {31'b0, halt_req}, 32'h0);
    rd(7'h10, d); chk("R2 only enable taken", d, 32'h1);
    hart_in_reset = 1'b1; tick(2); hart_in_reset = 1'b0; tick(1);
    chk("R2 flag not set by blocked write", {31'b0, halt_req}, 32'h0);
    wr(32'h8000_0001);
    chk("R3 halt raised", {31'b0, halt_req}, 32'h1);
    wr(32'h0);
    chk("R2 deactivate drops halt", {31'b0, halt_req}, 32'h0);
    rd(7'h10, d); chk("R2 ctrl cleared", d, 32'h0);
    wr(32'h1);
    rd(7'h11, d); chk("R2 havereset cleared by deactivation", d & 32'h000C_0000, 32'h0);
  endtask

  task automatic t_hartsel;
    logic [31:0] d;
    wr(32'h07FF_FFC1);
    rd(7'h10, d); chk("R11 hart select reads zero", d, 32'h1);
    rd(7'h12, d); chk("R11 other address zero", d, 32'h0);
  endtask

  task automatic t_halt;
    logic [31:0] d;
    wr(32'h8000_0001);
    chk("R3 halt_req set", {31'b0, halt_req}, 32'h1);
    rd(7'h10, d); chk("R3 halt reads back", d, 32'h8000_0001);
    hart_halted = 1'b1; tick(1);
    rd(7'h11, d); chk("R7 halted pair", d & 32'h0F00, 32'h0300);
    wr(32'h1);
    chk("R3 halt_req cleared", {31'b0, halt_req}, 32'h0);
  endtask

  task automatic t_resume;
    logic [31:0] d;
    wr(32'h4000_0001);
    chk("R4 resume_req raised", {31'b0, resume_req}, 32'h1);
    rd(7'h11, d); chk("R6 ack clear while pending", d & 32'h0003_0000, 32'h0);
    tick(3);
    chk("R4 resume_req held", {31'b0, resume_req}, 32'h1);
    hart_halted = 1'b0; hart_running = 1'b1; tick(1);
    chk("R4 resume_req dropped", {31'b0, resume_req}, 32'h0);
    rd(7'h11, d); chk("R6 ack set", d & 32'h0003_0000, 32'h0003_0000);
    chk("R7 running pair", d & 32'h0F00, 32'h0C00);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    hart_running = 1'b0; hart_halted = 1'b1; tick(1);
    wr(32'hC000_0001);
    chk("R5 halt taken", {31'b0, halt_req}, 32'h1);
    chk("R5 resume masked", {31'b0, resume_req}, 32'h0);
    tick(1);
    chk("R5 resume still masked", {31'b0, resume_req}, 32'h0);
    rd(7'h11, d); chk("R5 ack unchanged", d & 32'h0003_0000, 32'h0003_0000);
    wr(32'h1);
  endtask

  task automatic t_hor;
    hart_halted = 1'b0;
    wr(32'h9);
    hart_in_reset = 1'b1; tick(1);
    chk("R8 halt during reset", {31'b0, halt_req}, 32'h1);
    hart_in_reset = 1'b0; tick(1);
    chk("R8 halt after reset", {31'b0, halt_req}, 32'h1);
    tick(2);
    chk("R8 halt held until halted", {31'b0, halt_req}, 32'h1);
    hart_halted = 1'b1; tick(1);
    chk("R8 halt released", {31'b0, halt_req}, 32'h0);
    hart_halted = 1'b0;
    hart_in_reset = 1'b1; tick(2); hart_in_reset = 1'b0; tick(1);
    chk("R8 flag is sticky", {31'b0, halt_req}, 32'h1);
    hart_halted = 1'b1; tick(1); hart_halted = 1'b0;
    wr(32'h5);
    hart_in_reset = 1'b1; tick(2); hart_in_reset = 1'b0; tick(1);
    chk("R8 flag cleared", {31'b0, halt_req}, 32'h0);
  endtask

  task automatic t_ackrst;
    logic [31:0] d;
    rd(7'h11, d); chk("R9 havereset set", d & 32'h000C_0000, 32'h000C_0000);
    wr(32'h1);
    rd(7'h11, d); chk("R9 havereset stays", d & 32'h000C_0000, 32'h000C_0000);
    wr(32'h1000_0001);
    rd(7'h11, d); chk("R9 havereset acked", d & 32'h000C_0000, 32'h0);
  endtask

  task automatic t_ndm;
    logic [31:0] d;
    wr(32'h3);
    chk("R10 sys reset driven", {31'b0, sys_reset_req}, 32'h1);
    rd(7'h10, d); chk("R10 ndm reads back", d, 32'h3);
    rd(7'h11, d); chk("R10 pending set", d & 32'h0100_0000, 32'h0100_0000);
    hart_in_reset = 1'b1; tick(1);
    wr(32'h1);
    chk("R10 sys reset released", {31'b0, sys_reset_req}, 32'h0);
    tick(1);
    rd(7'h11, d); chk("R10 pending while in reset", d & 32'h0100_0000, 32'h0100_0000);
    hart_in_reset = 1'b0; tick(1);
    rd(7'h11, d); chk("R10 pending cleared", d & 32'h0100_0000, 32'h0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_inactive();
    t_hartsel();
    t_halt();
    t_resume();
    t_mask();
    t_hor();
    t_ackrst();
    t_ndm();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule